// File: doc/BRIEF.md
# Dual-Transport Host Byte Link

This block sits between an external host and a command controller. On the controller side it offers one plain byte interface: a received byte with a single-cycle strobe, and a transmit byte with a send request and a busy flag. On the host side it provides two transports. A mode input picks one of them at runtime.

With the mode input low, the link is an asynchronous serial line. It carries one start bit, eight data bits (least significant first) and one stop bit, with no parity. Each bit lasts a fixed number of clock cycles. With the mode input high, the link is a parallel byte bus that runs on the same clock as the host. A write strobe captures input bytes. Output bytes are shown with a valid flag, and a 2-bit input sets how long that flag stays high.

The controller's busy and error flags are routed to the status pins of whichever transport is active. The transport that is not selected keeps its output drivers idle.

Top module: `byte_host_bridge`

## Requirements
- R1: In serial mode, an accepted send produces on `ser_tx` a low start bit, then the eight data bits least significant first, then a high stop bit. Each bit lasts CLKS_PER_BIT cycles, and the line rests high between frames.
- R2: In serial mode, `ser_rx` passes through a two-stage synchroniser. A correctly framed byte is delivered on `rx_byte` with `rx_stb` high for one cycle.
- R3: A falling edge on `ser_rx` is sampled again halfway through the start bit. If the line is high again at that point, the edge is dropped and no byte is delivered.
- R4: If a frame's stop bit samples low, its byte is discarded. The receiver then waits for the line to go high before it looks for a new start bit.
- R5: In parallel mode, each cycle with `par_wr` high captures `par_din`. That byte appears on `rx_byte` with `rx_stb` high two cycles later. Cycles with `par_wr` low deliver nothing, and strobes on consecutive cycles each deliver a byte.
- R6: In parallel mode, an accepted send drives the byte on `par_dout` with `par_valid` high for exactly `hold_sel`+1 consecutive cycles, which gives 1 to 4 cycles.
- R7: A send is accepted only when `tx_busy` is low. `tx_busy` rises in the cycle after acceptance and stays high until the stop bit (serial) or the last hold cycle (parallel) ends. A serial frame keeps `tx_busy` high for 10×CLKS_PER_BIT cycles. A send request made while busy is ignored.
- R8: One cycle after any change, `ctl_busy`/`ctl_err` appear on `ser_busy_o`/`ser_err_o` in serial mode or on `par_busy_o`/`par_err_o` in parallel mode. The status pins of the other mode read 0.
- R9: The transport that is not selected is idle and ignored. In parallel mode `ser_tx` stays high and serial frames on `ser_rx` deliver nothing. In serial mode `par_valid` stays low and `par_wr` pulses deliver nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_par | input | 1 | Transport select: 0 serial, 1 parallel |
| ser_rx | input | 1 | Serial line from host |
| ser_tx | output | 1 | Serial line to host, idle high |
| ser_busy_o | output | 1 | Controller busy, serial mode |
| ser_err_o | output | 1 | Controller error, serial mode |
| par_din | input | DATA_W | Parallel input byte |
| par_wr | input | 1 | Parallel write strobe |
| par_dout | output | DATA_W | Parallel output byte |
| par_valid | output | 1 | Parallel output byte valid |
| par_busy_o | output | 1 | Controller busy, parallel mode |
| par_err_o | output | 1 | Controller error, parallel mode |
| hold_sel | input | HOLD_W | Parallel output hold, hold_sel+1 cycles |
| rx_byte | output | DATA_W | Byte to controller |
| rx_stb | output | 1 | One-cycle strobe for rx_byte |
| tx_byte | input | DATA_W | Byte from controller |
| tx_send | input | 1 | Send request from controller |
| tx_busy | output | 1 | Transmit path occupied |
| ctl_busy | input | 1 | Controller busy flag |
| ctl_err | input | 1 | Controller error flag |

## Verification
The bench builds the block with CLKS_PER_BIT = 16, DATA_W = 8 and HOLD_W = 2. The short bit period keeps each serial frame to 160 cycles. That leaves room in the run for several frames, a start glitch shorter than half a bit, a frame with a bad stop bit, and a send request made in the middle of a frame. The 2-bit hold width lets the bench sweep all four hold lengths, and it checks that the busy window matches each one.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_WAITHI
  } rx_state_t;
endpackage

// File: rtl/hb_uart_rx.sv
module hb_uart_rx #(
  parameter int DATA_W       = 8,
  parameter int CLKS_PER_BIT = 200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              line_i,
  output logic [DATA_W-1:0] byte_o,
  output logic              stb_o
);
  import hb_pkg::*;
  localparam int CW   = $clog2(CLKS_PER_BIT);
  localparam int HALF = CLKS_PER_BIT / 2;
  localparam int BW   = $clog2(DATA_W);

  logic            s1, s2;
  rx_state_t       st;
  logic [CW-1:0]   cnt;
  logic [BW-1:0]   bitn;
  logic [DATA_W-1:0] shr;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= line_i;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk) begin
    stb_o <= 1'b0;
    if (rst || !en) begin
      st     <= RX_IDLE;
      cnt    <= '0;
      bitn   <= '0;
      shr    <= '0;
      byte_o <= '0;
    end else begin
      case (st)
        RX_IDLE: begin
          cnt <= '0;
          if (!s2) st <= RX_START;
        end
        RX_START: begin
          if (cnt == CW'(HALF - 1)) begin
            cnt  <= '0;
            bitn <= '0;
            st   <= s2 ? RX_IDLE : RX_DATA;
          end else cnt <= cnt + 1'b1;
        end
        RX_DATA: begin
          if (cnt == CW'(CLKS_PER_BIT - 1)) begin
            cnt <= '0;
            shr <= {s2, shr[DATA_W-1:1]};
            if (bitn == BW'(DATA_W - 1)) st <= RX_STOP;
            else bitn <= bitn + 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        RX_STOP: begin
          if (cnt == CW'(CLKS_PER_BIT - 1)) begin
            cnt <= '0;
            if (s2) begin
              byte_o <= shr;
              stb_o  <= 1'b1;
              st     <= RX_IDLE;
            end else st <= RX_WAITHI;
          end else cnt <= cnt + 1'b1;
        end
        RX_WAITHI: if (s2) st <= RX_IDLE;
        default: st <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hb_uart_tx.sv
module hb_uart_tx #(
  parameter int DATA_W       = 8,
  parameter int CLKS_PER_BIT = 200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              go,
  input  logic [DATA_W-1:0] data_i,
  output logic              line_o,
  output logic              busy_o
);
  localparam int CW = $clog2(CLKS_PER_BIT);
  localparam int FW = DATA_W + 2;
  localparam int NW = $clog2(FW);

  logic [CW-1:0] cnt;
  logic [NW-1:0] nleft;
  logic [FW-1:0] shr;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      line_o <= 1'b1;
      busy_o <= 1'b0;
      cnt    <= '0;
      nleft  <= '0;
      shr    <= '1;
    end else if (!busy_o) begin
      if (go) begin
        line_o <= 1'b0;
        shr    <= {1'b1, 1'b1, data_i};
        nleft  <= NW'(FW - 1);
        cnt    <= '0;
        busy_o <= 1'b1;
      end
    end else if (cnt == CW'(CLKS_PER_BIT - 1)) begin
      cnt <= '0;
      if (nleft == '0) begin
        busy_o <= 1'b0;
        line_o <= 1'b1;
      end else begin
        line_o <= shr[0];
        shr    <= {1'b1, shr[FW-1:1]};
        nleft  <= nleft - 1'b1;
      end
    end else cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/hb_par_port.sv
module hb_par_port #(
  parameter int DATA_W = 8,
  parameter int HOLD_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic              go,
  input  logic [DATA_W-1:0] data_i,
  input  logic [HOLD_W-1:0] hold_i,
  output logic [DATA_W-1:0] rx_o,
  output logic              stb_o,
  output logic [DATA_W-1:0] dout_o,
  output logic              valid_o
);
  logic [HOLD_W-1:0] hcnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      rx_o  <= '0;
      stb_o <= 1'b0;
    end else begin
      stb_o <= wr_i;
      if (wr_i) rx_o <= din_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      dout_o  <= '0;
      valid_o <= 1'b0;
      hcnt    <= '0;
    end else if (!valid_o) begin
      if (go) begin
        dout_o  <= data_i;
        valid_o <= 1'b1;
        hcnt    <= hold_i;
      end
    end else if (hcnt == '0) begin
      valid_o <= 1'b0;
    end else begin
      hcnt <= hcnt - 1'b1;
    end
  end
endmodule

// File: rtl/byte_host_bridge.sv
module byte_host_bridge #(
  parameter int DATA_W       = 8,
  parameter int CLKS_PER_BIT = 200,
  parameter int HOLD_W       = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_par,
  input  logic              ser_rx,
  output logic              ser_tx,
  output logic              ser_busy_o,
  output logic              ser_err_o,
  input  logic [DATA_W-1:0] par_din,
  input  logic              par_wr,
  output logic [DATA_W-1:0] par_dout,
  output logic              par_valid,
  output logic              par_busy_o,
  output logic              par_err_o,
  input  logic [HOLD_W-1:0] hold_sel,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_stb,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              tx_send,
  output logic              tx_busy,
  input  logic              ctl_busy,
  input  logic              ctl_err
);
  logic              s_busy, s_stb, p_stb, accept;
  logic [DATA_W-1:0] s_byte, p_byte;

  assign tx_busy = s_busy | par_valid;
  assign accept  = tx_send & ~tx_busy;

  hb_uart_rx #(.DATA_W(DATA_W), .CLKS_PER_BIT(CLKS_PER_BIT)) u_srx (
    .clk(clk), .rst(rst), .en(~mode_par), .line_i(ser_rx),
    .byte_o(s_byte), .stb_o(s_stb));

  hb_uart_tx #(.DATA_W(DATA_W), .CLKS_PER_BIT(CLKS_PER_BIT)) u_stx (
    .clk(clk), .rst(rst), .en(~mode_par), .go(accept), .data_i(tx_byte),
    .line_o(ser_tx), .busy_o(s_busy));

  hb_par_port #(.DATA_W(DATA_W), .HOLD_W(HOLD_W)) u_par (
    .clk(clk), .rst(rst), .en(mode_par), .wr_i(par_wr), .din_i(par_din),
    .go(accept), .data_i(tx_byte), .hold_i(hold_sel),
    .rx_o(p_byte), .stb_o(p_stb), .dout_o(par_dout), .valid_o(par_valid));

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_byte    <= '0;
      rx_stb     <= 1'b0;
      ser_busy_o <= 1'b0;
      ser_err_o  <= 1'b0;
      par_busy_o <= 1'b0;
      par_err_o  <= 1'b0;
    end else begin
      rx_stb     <= mode_par ? p_stb : s_stb;
      rx_byte    <= mode_par ? p_byte : s_byte;
      ser_busy_o <= ~mode_par & ctl_busy;
      ser_err_o  <= ~mode_par & ctl_err;
      par_busy_o <= mode_par & ctl_busy;
      par_err_o  <= mode_par & ctl_err;
    end
  end
endmodule

// File: rtl/hb_checker.sv
module hb_checker #(
  parameter int DATA_W = 8,
  parameter int HOLD_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              mode_par,
  input logic              ser_tx,
  input logic              par_valid,
  input logic              par_wr,
  input logic [DATA_W-1:0] par_din,
  input logic              rx_stb,
  input logic [DATA_W-1:0] rx_byte,
  input logic              tx_send,
  input logic              tx_busy,
  input logic [HOLD_W-1:0] hold_sel,
  input logic              ctl_busy,
  input logic              par_busy_o,
  input logic              ser_busy_o
);
  logic [HOLD_W+1:0] vrun;
  logic [HOLD_W-1:0] held;

  always_ff @(posedge clk) begin
    if (rst) begin
      vrun <= '0;
      held <= '0;
    end else begin
      vrun <= par_valid ? vrun + 1'b1 : '0;
      if (tx_send && !tx_busy && mode_par) held <= hold_sel;
    end
  end

  // R9
  tx_idle_par_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_par && $past(mode_par)) |-> ser_tx);
  // R9
  valid_idle_ser_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(mode_par) |-> !par_valid);
  // R5
  par_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_stb && $past(mode_par) && $past(mode_par, 2)) |->
      ($past(par_wr, 2) && rx_byte == $past(par_din, 2)));
  // R7
  busy_after_send_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_send && !tx_busy) |=> tx_busy);
  // R6
  hold_len_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(par_valid) && mode_par && $past(mode_par)) |->
      (vrun == {2'b00, held} + 1'b1));
  // R8
  status_route_chk: assert property (@(posedge clk) disable iff (rst)
    $past(mode_par) |-> (par_busy_o == $past(ctl_busy) && !ser_busy_o));
endmodule

bind byte_host_bridge hb_checker #(.DATA_W(DATA_W), .HOLD_W(HOLD_W)) u_chk (
  .clk(clk), .rst(rst), .mode_par(mode_par), .ser_tx(ser_tx),
  .par_valid(par_valid), .par_wr(par_wr), .par_din(par_din),
  .rx_stb(rx_stb), .rx_byte(rx_byte), .tx_send(tx_send), .tx_busy(tx_busy),
  .hold_sel(hold_sel), .ctl_busy(ctl_busy), .par_busy_o(par_busy_o),
  .ser_busy_o(ser_busy_o));

// File: tb/sim_byte_host_bridge.sv
`timescale 1ns/1ps
module sim_byte_host_bridge;
  localparam int CPB = 16;
  localparam int DW  = 8;
  localparam int HW  = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1, mode_par = 1'b0, ser_rx = 1'b1, par_wr = 1'b0;
  logic tx_send = 1'b0, ctl_busy = 1'b0, ctl_err = 1'b0;
  logic [DW-1:0] par_din = '0, tx_byte = '0;
  logic [HW-1:0] hold_sel = '0;
  logic ser_tx, ser_busy_o, ser_err_o, par_valid, par_busy_o, par_err_o;
  logic rx_stb, tx_busy;
  logic [DW-1:0] par_dout, rx_byte;

  byte_host_bridge #(.DATA_W(DW), .CLKS_PER_BIT(CPB), .HOLD_W(HW)) u0 (
    .clk(clk), .rst(rst), .mode_par(mode_par), .ser_rx(ser_rx),
    .ser_tx(ser_tx), .ser_busy_o(ser_busy_o), .ser_err_o(ser_err_o),
    .par_din(par_din), .par_wr(par_wr), .par_dout(par_dout),
    .par_valid(par_valid), .par_busy_o(par_busy_o), .par_err_o(par_err_o),
    .hold_sel(hold_sel), .rx_byte(rx_byte), .rx_stb(rx_stb),
    .tx_byte(tx_byte), .tx_send(tx_send), .tx_busy(tx_busy),
    .ctl_busy(ctl_busy), .ctl_err(ctl_err));

  int checks = 0, fails = 0;
  logic [DW-1:0] rxq[$];
  logic [DW-1:0] txq[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Receive-side monitor: scoreboard of bytes towards the controller
  always @(negedge clk) begin
    if (!rst && rx_stb) begin
      if (rxq.size() == 0) check(1'b0, "R2/R3/R4/R5/R9 unexpected rx_stb", rx_byte, 0);
      else begin
        logic [DW-1:0] e;
        e = rxq.pop_front();
        check(rx_byte == e, "R2/R5 rx_byte", rx_byte, e);
      end
    end
  end

  // Serial transmit monitor: decodes frames on ser_tx (R1)
  initial begin
    forever begin
      @(negedge ser_tx);
      if (!rst && !mode_par) begin
        logic [DW-1:0] got;
        logic [DW-1:0] e;
        repeat (CPB/2) @(negedge clk);
        check(ser_tx == 1'b0, "R1 start bit", ser_tx, 0);
        for (int i = 0; i < DW; i++) begin
          repeat (CPB) @(negedge clk);
          got[i] = ser_tx;
        end
        repeat (CPB) @(negedge clk);
        check(ser_tx == 1'b1, "R1 stop bit", ser_tx, 1);
        if (txq.size() == 0) check(1'b0, "R1/R7 unexpected frame", got, 0);
        else begin
          e = txq.pop_front();
          check(got == e, "R1 frame data", got, e);
        end
      end
    end
  end

  task automatic ser_frame(input logic [DW-1:0] b, input logic stop);
    @(negedge clk) ser_rx = 1'b0;
    repeat (CPB) @(negedge clk);
    for (int i = 0; i < DW; i++) begin
      ser_rx = b[i];
      repeat (CPB) @(negedge clk);
    end
    ser_rx = stop;
    repeat (CPB) @(negedge clk);
    ser_rx = 1'b1;
    repeat (CPB) @(negedge clk);
  endtask

  task automatic par_write(input logic [DW-1:0] b, input bit expect_it);
    @(negedge clk);
    par_din = b;
    par_wr  = 1'b1;
    if (expect_it) rxq.push_back(b);
    @(negedge clk);
    par_wr  = 1'b0;
    par_din = ~b;
  endtask

  task automatic ser_send(input logic [DW-1:0] b, input bit inject);
    int n;
    txq.push_back(b);
    @(negedge clk);
    tx_byte = b;
    tx_send = 1'b1;
    @(negedge clk);
    tx_send = 1'b0;
    n = 0;
    while (tx_busy) begin
      n++;
      if (inject && n == 40) begin
        tx_byte = 8'h99;
        tx_send = 1'b1;
      end else tx_send = 1'b0;
      check(par_valid == 1'b0, "R9 valid idle in serial", par_valid, 0);
      @(negedge clk);
    end
    tx_send = 1'b0;
    check(n == 10*CPB, "R7 serial busy length", n, 10*CPB);
  endtask

  task automatic par_send(input logic [DW-1:0] b, input logic [HW-1:0] h);
    int n, nb;
    hold_sel = h;
    @(negedge clk);
    tx_byte = b;
    tx_send = 1'b1;
    @(negedge clk);
    tx_send = 1'b0;
    n = 0;
    nb = 0;
    while (tx_busy) begin
      nb++;
      if (par_valid) begin
        n++;
        check(par_dout == b, "R6 par_dout", par_dout, b);
      end
      check(ser_tx == 1'b1, "R9 tx idle in parallel", ser_tx, 1);
      @(negedge clk);
    end
    check(n == int'(h) + 1, "R6 valid length", n, int'(h) + 1);
    check(nb == int'(h) + 1, "R7 parallel busy length", nb, int'(h) + 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_up();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // Reset state
    check(ser_tx == 1'b1, "R1 reset tx idle", ser_tx, 1);
    check(par_valid == 1'b0, "R9 reset valid", par_valid, 0);
    check(tx_busy == 1'b0, "R7 reset busy", tx_busy, 0);
    check(rx_stb == 1'b0, "R2 reset stb", rx_stb, 0);

    // Serial receive (R2)
    foreach (rxq[i]) ;
    rxq.push_back(8'hA5); ser_frame(8'hA5, 1'b1);
    rxq.push_back(8'h3C); ser_frame(8'h3C, 1'b1);
    rxq.push_back(8'h00); ser_frame(8'h00, 1'b1);
    rxq.push_back(8'hFF); ser_frame(8'hFF, 1'b1);
    check(rxq.size() == 0, "R2 all serial bytes received", rxq.size(), 0);

    // Short glitch rejected (R3)
    @(negedge clk) ser_rx = 1'b0;
    repeat (4) @(negedge clk);
    ser_rx = 1'b1;
    repeat (3*CPB) @(negedge clk);
    // Bad stop bit discarded (R4), then recovery
    ser_frame(8'h77, 1'b0);
    rxq.push_back(8'h81); ser_frame(8'h81, 1'b1);
    check(rxq.size() == 0, "R3/R4 recovery byte received", rxq.size(), 0);

    // Serial transmit (R1, R7), with a send request mid-frame ignored
    ser_send(8'h5A, 1'b0);
    ser_send(8'hC3, 1'b1);
    repeat (3*CPB) @(negedge clk);
    check(txq.size() == 0, "R1/R7 frames consumed", txq.size(), 0);
    check(ser_tx == 1'b1, "R1 line rests high", ser_tx, 1);

    // par_wr ignored in serial mode (R9)
    par_write(8'h42, 1'b0);
    repeat (4) @(negedge clk);

    // Status routing serial (R8)
    ctl_busy = 1'b1; ctl_err = 1'b1;
    @(negedge clk); @(negedge clk);
    check(ser_busy_o && ser_err_o, "R8 serial status on", {ser_busy_o, ser_err_o}, 3);
    check(!par_busy_o && !par_err_o, "R8 par status off", {par_busy_o, par_err_o}, 0);

    // Parallel mode
    mode_par = 1'b1;
    @(negedge clk); @(negedge clk);
    check(par_busy_o && par_err_o, "R8 par status on", {par_busy_o, par_err_o}, 3);
    check(!ser_busy_o && !ser_err_o, "R8 serial status off", {ser_busy_o, ser_err_o}, 0);
    ctl_busy = 1'b0; ctl_err = 1'b0;
    @(negedge clk); @(negedge clk);
    check(!par_busy_o && !par_err_o, "R8 par status follows", {par_busy_o, par_err_o}, 0);

    // Parallel writes with gaps and back to back (R5)
    par_write(8'h11, 1'b1);
    repeat (3) @(negedge clk);
    par_write(8'h22, 1'b1);
    @(negedge clk);
    par_din = 8'h33; par_wr = 1'b1; rxq.push_back(8'h33);
    @(negedge clk);
    par_din = 8'h44; rxq.push_back(8'h44);
    @(negedge clk);
    par_wr = 1'b0; par_din = 8'hEE;
    repeat (4) @(negedge clk);
    check(rxq.size() == 0, "R5 parallel bytes received", rxq.size(), 0);

    // Serial frame ignored in parallel mode (R9)
    ser_frame(8'h55, 1'b1);

    // Parallel output, all hold values (R6, R7)
    for (int h = 0; h < 4; h++) par_send(8'hB0 + 8'(h), HW'(h));
    check(txq.size() == 0, "R9 no serial frame in parallel", txq.size(), 0);

    repeat (10) @(negedge clk);
    check(rxq.size() == 0, "R5 scoreboard drained", rxq.size(), 0);
    finish_up();
  end
endmodule